// File: doc/BRIEF.md
# Opcode-Driven 64-Bit Arithmetic/Logic Unit

This block computes one 64-bit result from two 64-bit operands, a 4-bit operation code and a 6-bit shift count. It provides wrapping addition and subtraction, and a signed less-than test that returns a full word equal to 0 or 1. It also provides logical left and right shifts of the first operand. A single shared adder serves addition, subtraction and the comparison. One barrel shifter serves both shift directions.

Every operation code outside the five legal ones yields a zero result and raises an illegal-operation flag. One code is set aside as reserved and must never be issued. A parameter chooses between a purely combinational result and a result captured in an output register. The register option is the default. In that case each set of inputs shows up on the outputs one clock later, and an active-low asynchronous reset clears both outputs.

The block has no sequencing states. Its only stored state is the optional output register together with the `primed` flag used by the checks. The flag is set on the first clock edge after reset.

Top module: `alu64_core`

## Requirements
- R1: Opcode 4'b0001 gives result = op_a + op_b modulo 2^64.
- R2: Opcode 4'b0010 gives result = op_a - op_b modulo 2^64.
- R3: Opcode 4'b1011 gives result = 64'h1 when op_a is less than op_b as two's-complement numbers, else 64'h0; bits 63:1 are always zero.
- R4: Opcode 4'b1110 gives op_a shifted right by shamt (0..63) with zeros shifted in at bit 63.
- R5: Opcode 4'b1100 gives op_a shifted left by shamt (0..63) with zeros shifted in at bit 0.
- R6: Reserved opcode 4'b1000 gives result = 0 and illegal_op = 1.
- R7: Every other unlisted opcode gives result = 0 and illegal_op = 1; the five legal opcodes give illegal_op = 0. Whenever illegal_op is 1, result is 0.
- R8: With REG_OUT = 1, result and illegal_op reflect the inputs sampled at the previous rising clock edge, and while rst_n is low both outputs are 0.
- R9: shamt has no effect on opcodes 4'b0001, 4'b0010 and 4'b1011, and op_b has no effect on the two shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 64 | First operand; also the shifted value |
| op_b | input | 64 | Second operand |
| opcode | input | 4 | Operation select |
| shamt | input | 6 | Shift count, 0 to 63 |
| result | output | 64 | Operation result |
| illegal_op | output | 1 | High for any opcode that is not legal |

## Verification
A fault in the shared adder's invert or carry-in control would show up as a wrong sum, difference or comparison bit in the cycle right after the operands are applied. A faulty shifter stage would show up as a wrong pattern in that same cycle, but only for shift counts that have that stage's bit set. Constrained random operands with corner values and shift counts, together with directed boundaries, make such faults appear within a few cycles. A bad decode or output-register path shows up at once as a nonzero result next to a raised illegal flag, or as a flag on a legal opcode.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SLT  = 4'b1011,
        OP_SHR  = 4'b1110,
        OP_SHL  = 4'b1100,
        OP_RSVD = 4'b1000
    } alu_op_e;

    typedef struct packed {
        logic add;
        logic sub;
        logic slt;
        logic shr;
        logic shl;
        logic bad;
    } alu_sel_t;

endpackage

// File: rtl/alu64_decode.sv
module alu64_decode
    import alu64_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_sel_t         sel
);

    always_comb begin
        sel = '0;
        unique case (opcode)
            OP_ADD:  sel.add = 1'b1;
            OP_SUB:  sel.sub = 1'b1;
            OP_SLT:  sel.slt = 1'b1;
            OP_SHR:  sel.shr = 1'b1;
            OP_SHL:  sel.shl = 1'b1;
            OP_RSVD: sel.bad = 1'b1;
            default: sel.bad = 1'b1;
        endcase
    end

    // R7: exactly one selector per opcode
    always_comb begin
        a_r7_one_select: assert ($countones(sel) == 1);
    end

endmodule

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              lt_signed
);

    logic [DATA_W-1:0] rhs_eff;
    logic              lhs_neg;
    logic              rhs_neg;

    assign rhs_eff = rhs ^ {DATA_W{do_sub}};
    assign sum     = lhs + rhs_eff + {{(DATA_W-1){1'b0}}, do_sub};
    assign lhs_neg = lhs[DATA_W-1];
    assign rhs_neg = rhs[DATA_W-1];

    // signs differ: the negative one is smaller; else difference sign decides
    always_comb begin
        if (lhs_neg != rhs_neg) lt_signed = lhs_neg;
        else                    lt_signed = sum[DATA_W-1];
    end

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
    parameter int DATA_W = 64,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SH_W-1:0]   amount,
    input  logic              to_left,
    output logic [DATA_W-1:0] dst
);

    logic [DATA_W-1:0] src_rev;
    logic [DATA_W-1:0] out_rev;
    logic [DATA_W-1:0] stage [0:SH_W];

    genvar j;
    generate
        for (j = 0; j < DATA_W; j++) begin : g_rev
            assign src_rev[j] = src[DATA_W-1-j];
            assign out_rev[j] = stage[SH_W][DATA_W-1-j];
        end
    endgenerate

    assign stage[0] = to_left ? src_rev : src;

    genvar i;
    generate
        for (i = 0; i < SH_W; i++) begin : g_stage
            assign stage[i+1] = amount[i] ? (stage[i] >> (2 ** i)) : stage[i];
        end
    endgenerate

    assign dst = to_left ? out_rev : stage[SH_W];

endmodule

// File: rtl/alu64_core.sv
module alu64_core
    import alu64_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    alu_sel_t          sel;
    logic [DATA_W-1:0] arith;
    logic              lt_flag;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] res_next;
    logic              ill_next;

    alu64_decode u_decode (
        .opcode (opcode),
        .sel    (sel)
    );

    alu64_addsub #(.DATA_W(DATA_W)) u_addsub (
        .lhs       (op_a),
        .rhs       (op_b),
        .do_sub    (sel.sub | sel.slt),
        .sum       (arith),
        .lt_signed (lt_flag)
    );

    alu64_shift #(.DATA_W(DATA_W)) u_shift (
        .src     (op_a),
        .amount  (shamt),
        .to_left (sel.shl),
        .dst     (shifted)
    );

    always_comb begin
        res_next = '0;
        ill_next = sel.bad;
        if (sel.add || sel.sub)      res_next = arith;
        else if (sel.slt)            res_next = {{(DATA_W-1){1'b0}}, lt_flag};
        else if (sel.shr || sel.shl) res_next = shifted;
    end

    logic primed;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result     <= '0;
                    illegal_op <= 1'b0;
                    primed     <= 1'b0;
                end else begin
                    result     <= res_next;
                    illegal_op <= ill_next;
                    primed     <= 1'b1;
                end
            end

            a_r1_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_ADD) |-> result == $past(op_a) + $past(op_b));
            a_r2_sub_wraps: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_SUB) |-> result == $past(op_a) - $past(op_b));
            a_r3_slt_word: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_SLT) |-> result[DATA_W-1:1] == '0);
            a_r4_shr_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_SHR && $past(shamt) != '0) |-> !result[DATA_W-1]);
            a_r5_shl_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_SHL && $past(shamt) != '0) |-> !result[0]);
            a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(opcode) == OP_RSVD) |-> (illegal_op && result == '0));
        end else begin : g_comb
            assign result     = res_next;
            assign illegal_op = ill_next;
            assign primed     = 1'b1;
        end
    endgenerate

    a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> result == '0);

endmodule

// File: tb/tb_alu64_core.sv
module tb_alu64_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [5:0]  shamt = '0;
    logic [63:0] result;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu64_core dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .shamt(shamt), .result(result), .illegal_op(illegal_op)
    );

    function automatic logic [63:0] model_res(input logic [63:0] a, input logic [63:0] b,
                                              input logic [3:0] op, input logic [5:0] sh);
        case (op)
            4'b0001: return a + b;                                  // R1
            4'b0010: return a - b;                                  // R2
            4'b1011: return ($signed(a) < $signed(b)) ? 64'h1 : 64'h0; // R3
            4'b1110: return a >> sh;                                // R4
            4'b1100: return a << sh;                                // R5
            default: return 64'h0;                                  // R6 R7
        endcase
    endfunction

    function automatic logic model_ill(input logic [3:0] op);
        return !(op == 4'b0001 || op == 4'b0010 || op == 4'b1011 ||
                 op == 4'b1110 || op == 4'b1100);
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0001: return "R1";
            4'b0010: return "R2";
            4'b1011: return "R3";
            4'b1110: return "R4";
            4'b1100: return "R5";
            4'b1000: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] op, input logic [5:0] sh, input string tag);
        logic [63:0] exp_r;
        logic        exp_i;
        exp_r = model_res(a, b, op, sh);
        exp_i = model_ill(op);
        op_a = a; op_b = b; opcode = op; shamt = sh;
        @(posedge clk);
        @(negedge clk);   // R8: one register stage
        checks++;
        if (result !== exp_r || illegal_op !== exp_i) begin
            errors++;
            $display("FAIL %s %s op=%b a=%h b=%h sh=%0d result=%h expected=%h illegal=%b expected=%b",
                     req_of(op), tag, op, a, b, sh, result, exp_r, illegal_op, exp_i);
        end
    endtask

    function automatic logic [63:0] pick64();
        case ($urandom_range(0, 7))
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h7FFF_FFFF_FFFF_FFFF;
            4: return 64'h1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic logic [3:0] pick_op();
        case ($urandom_range(0, 7))
            0: return 4'b0001;
            1: return 4'b0010;
            2: return 4'b1011;
            3: return 4'b1110;
            4: return 4'b1100;
            5: return 4'b1000;
            default: return 4'($urandom_range(0, 15));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        opcode = 4'b0001; op_a = 64'h5; op_b = 64'h7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R8 reset state
        if (result !== 64'h0 || illegal_op !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset result=%h expected=%h illegal=%b expected=0",
                     result, 64'h0, illegal_op);
        end
        rst_n = 1'b1;

        run(64'd2, 64'd2, 4'b0001, 6'd0, "two plus two");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'b0001, 6'd17, "add wrap");
        run(64'h0, 64'h1, 4'b0010, 6'd5, "sub wrap");
        run(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 4'b1011, 6'd0, "slt min<max");
        run(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 4'b1011, 6'd0, "slt max<min");
        run(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1011, 6'd9, "slt -2<-1");
        run(64'h1234, 64'h1234, 4'b1011, 6'd0, "slt equal");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD, 4'b1110, 6'd63, "shr 63");
        run(64'hA5A5_0000_FFFF_0001, 64'h0, 4'b1110, 6'd0, "shr 0");
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'hBEEF, 4'b1100, 6'd63, "shl 63");
        run(64'h8000_0000_0000_0001, 64'h0, 4'b1100, 6'd1, "shl 1");
        run(64'h1234, 64'h5678, 4'b1000, 6'd3, "reserved");
        run(64'h1234, 64'h5678, 4'b0000, 6'd3, "opcode 0000");
        run(64'h1234, 64'h5678, 4'b1111, 6'd3, "opcode 1111");
        // R9: vary shamt on arithmetic, op_b on shifts
        run(64'd100, 64'd23, 4'b0010, 6'd63, "R9 sub ignores shamt");
        run(64'hF0, 64'hFFFF, 4'b1110, 6'd4, "R9 shr ignores op_b");

        for (int k = 0; k < 600; k++) begin
            run(pick64(), pick64(), pick_op(), 6'($urandom_range(0, 63)), "random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule